// File: doc/BRIEF.md
# Ring-Oscillator Entropy Collector

This block is the register-side controller of a true random number generator. A single raw entropy bit arrives from a free-running ring oscillator. It passes through a two-flop synchronizer. While a collection runs, the block captures that bit once every programmable number of clock cycles and packs the captured bits into a bank of 32-bit result words. A 2-bit speed select goes back to the oscillator.

Software works through a plain 32-bit register bus with address, write enable, write data and registered read data. It programs the capture period, then sets the enable and the start bit through a masked control write. It polls until the start bit drops, and then reads the result words. A write to the soft-reset register returns every piece of state to its default.

Top module: `rtrng_ctrl`

## Requirements
- R1: A write to the control register (offset 0x400) changes only the control bits whose mask bit is set. The mask is write-data bits [21:16] and the new values are bits [5:0]. The control read value is {len[5:4], speed[3:2], enable[1], start[0]}.
- R2: The length field (control [5:4]) encodes 0→64, 1→128, 2→192 and 3→256 bits, which fills 2, 4, 6 or 8 words. A new collection first zeroes all result words, so the words beyond the selected length read as zero.
- R3: The speed field (control [3:2]) drives osc_speed_o. It changes only through a control write or a soft reset.
- R4: The start bit reads 1 while a collection runs and clears by itself on the cycle the last bit of the selected length is captured.
- R5: Setting start while enable is 0 has no effect: start stays 0 and the result words stay unchanged.
- R6: Clearing enable during a collection stops it and clears start. The bits already captured remain readable.
- R7: The sample-count register (offset 0x404, reset value 1000) sets the number of cycles between captures, so a collection of L bits with count N takes L·N cycles. A count of 0 behaves as 1.
- R8: Captured bits fill word 0 first, and each word from bit 31 downward.
- R9: The result words read at offsets 0x410 + 4·k for k = 0..7. Read data appears one cycle after the address. Any offset that is not mapped reads zero.
- R10: Writing a 1 in bit 0 at offset 0x004 returns the control, count and result state to reset values (control 0, count 1000, words 0).
- R11: A control write that leaves start unmasked and lands on the completion cycle still takes effect in its other fields, and start still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after bus_addr |
| entropy_i | input | 1 | Raw ring-oscillator bit, asynchronous |
| osc_speed_o | output | 2 | Ring speed select |

## Verification
The hardware clear of start on the final capture and a software control write can fall on the same clock edge. The bench provokes this by using a count of 0, so one bit is captured per cycle and a 64-bit collection ends exactly 64 edges after the start write. It then places a speed-only masked write on that 64th edge. The result is judged by reading control back: the new speed must be present and start must be 0, while osc_speed_o and both filled words show that neither action was lost.

// File: rtl/rtrng_pkg.sv
package rtrng_pkg;
   localparam int unsigned WORD_W = 32;

   localparam logic [11:0] OFS_SRST = 12'h004;
   localparam logic [11:0] OFS_CTL  = 12'h400;
   localparam logic [11:0] OFS_CNT  = 12'h404;
   localparam logic [11:0] OFS_DAT  = 12'h410;

   localparam int unsigned CTL_W = 6;

   typedef struct packed {
      logic [1:0] len;
      logic [1:0] speed;
      logic       en;
      logic       start;
   } ctl_t;
endpackage

// File: rtl/rtrng_sync.sv
module rtrng_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtrng_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rtrng_pacer.sv
module rtrng_pacer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             tick_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // a period of zero behaves as one: capture on every cycle
   assign limit  = (period_i == '0) ? '0 : period_i - CNT_W'(1);
   assign tick_o = run_i && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_i || !run_i)   cnt_q <= '0;
      else if (tick_o)            cnt_q <= '0;
      else                        cnt_q <= cnt_q + CNT_W'(1);
   end

   // R7
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && limit != '0 && !clr_i) |=> (!tick_o || !$stable(period_i)));
endmodule

// File: rtl/rtrng_fill.sv
module rtrng_fill #(
   parameter int unsigned NWORDS = 8,
   parameter int unsigned WORD_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     kick_i,
   input  logic                     tick_i,
   input  logic                     bit_i,
   input  logic [1:0]               len_i,
   output logic                     done_o,
   output logic [NWORDS*WORD_W-1:0] words_o
);
   localparam int unsigned TOTAL    = NWORDS * WORD_W;
   localparam int unsigned PTR_W    = $clog2(TOTAL);
   localparam int unsigned BIT_W    = $clog2(WORD_W);
   localparam int unsigned STEP_BITS = (NWORDS / 4) * WORD_W;

   if ((NWORDS % 4) != 0) begin : g_bad_words
      $error("rtrng_fill: NWORDS must be a multiple of 4");
   end
   if ((1 << BIT_W) != WORD_W) begin : g_bad_width
      $error("rtrng_fill: WORD_W must be a power of two");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] last_ptr;
   logic [PTR_W-BIT_W-1:0] wsel;
   logic [BIT_W-1:0] bpos;

   assign last_ptr = PTR_W'((32'(len_i) + 32'd1) * 32'(STEP_BITS) - 32'd1);
   assign done_o   = tick_i && (ptr_q >= last_ptr);
   assign wsel     = ptr_q[PTR_W-1:BIT_W];
   assign bpos     = BIT_W'(WORD_W - 1) - ptr_q[BIT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ptr_q <= '0;
      else if (clr_i || kick_i) ptr_q <= '0;
      else if (tick_i)          ptr_q <= ptr_q + PTR_W'(1);
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      word_q <= '0;
         else if (clr_i || kick_i)                        word_q <= '0;
         else if (tick_i && wsel == (PTR_W-BIT_W)'(k))    word_q[bpos] <= bit_i;
      end
      assign words_o[k*WORD_W +: WORD_W] = word_q;
   end

   // R2
   fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> (ptr_q == '0 && words_o == '0));
endmodule

// File: rtl/rtrng_ctrl.sv
module rtrng_ctrl
   import rtrng_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned NWORDS      = 8,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned CNT_RST     = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              entropy_i,
   output logic [1:0]        osc_speed_o
);
   localparam logic [ADDR_W-1:0] A_SRST = ADDR_W'(OFS_SRST);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFS_DAT);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("rtrng_ctrl: ADDR_W must cover offset 0x42C");
   end
   if (CNT_W > 32 || CNT_W < 1) begin : g_bad_cnt
      $error("rtrng_ctrl: CNT_W must be 1..32");
   end
   if (NWORDS != 8) begin : g_bad_nw
      $error("rtrng_ctrl: register map holds exactly eight result words");
   end

   // bus decode
   logic wr_ctl, wr_cnt, srst;
   assign wr_ctl = bus_we && (bus_addr == A_CTL);
   assign wr_cnt = bus_we && (bus_addr == A_CNT);
   assign srst   = bus_we && (bus_addr == A_SRST) && bus_wdata[0];

   logic unused_wbits;
   assign unused_wbits = ^{bus_wdata[31:22], bus_wdata[15:6]};

   // control register with per-bit write mask
   ctl_t ctl_q, ctl_d, ctl_wr;
   logic [CTL_W-1:0] wmask, wval;
   logic new_en, kick, coll_done, pace_tick, ent_sync;
   logic [CNT_W-1:0] cnt_q;
   logic [NWORDS*WORD_W-1:0] words;

   assign wmask  = bus_wdata[16 +: CTL_W];
   assign wval   = bus_wdata[CTL_W-1:0];
   assign ctl_wr = ctl_t'((ctl_q & ~wmask) | (wval & wmask));
   assign new_en = wr_ctl ? ctl_wr.en : ctl_q.en;
   assign kick   = wr_ctl && wmask[0] && wval[0] && new_en && !ctl_q.start;

   always_comb begin
      ctl_d = ctl_q;
      if (wr_ctl) begin
         ctl_d.len   = ctl_wr.len;
         ctl_d.speed = ctl_wr.speed;
         ctl_d.en    = ctl_wr.en;
      end
      if (!new_en)        ctl_d.start = 1'b0;
      else if (kick)      ctl_d.start = 1'b1;
      else if (coll_done) ctl_d.start = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (srst) ctl_q <= '0;
      else           ctl_q <= ctl_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= CNT_W'(CNT_RST);
      else if (srst)   cnt_q <= CNT_W'(CNT_RST);
      else if (wr_cnt) cnt_q <= bus_wdata[CNT_W-1:0];
   end

   assign osc_speed_o = ctl_q.speed;

   // datapath
   rtrng_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(entropy_i), .sync_o(ent_sync)
   );

   rtrng_pacer #(.CNT_W(CNT_W)) u_pacer (
      .clk(clk), .rst_n(rst_n), .clr_i(srst), .run_i(ctl_q.start),
      .period_i(cnt_q), .tick_o(pace_tick)
   );

   rtrng_fill #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .clr_i(srst), .kick_i(kick),
      .tick_i(pace_tick), .bit_i(ent_sync), .len_i(ctl_q.len),
      .done_o(coll_done), .words_o(words)
   );

   // registered read mux
   logic [31:0] rd_d, rdata_q;
   logic [ADDR_W-1:0] dat_off;
   logic hit;
   assign dat_off = bus_addr - A_DAT;

   always_comb begin
      rd_d = '0;
      hit  = 1'b0;
      if (bus_addr == A_CTL) begin
         rd_d = 32'(ctl_q);
         hit  = 1'b1;
      end
      if (bus_addr == A_CNT) begin
         rd_d = 32'(cnt_q);
         hit  = 1'b1;
      end
      for (int k = 0; k < int'(NWORDS); k++) begin
         if (dat_off == ADDR_W'(k * 4)) begin
            rd_d = words[k*WORD_W +: WORD_W];
            hit  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_d;
   end
   assign bus_rdata = rdata_q;

   // R5
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.start |-> ctl_q.en);
   // R4
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coll_done |=> !ctl_q.start);
   // R10
   srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctl_q == '0 && cnt_q == CNT_W'(CNT_RST) && words == '0));
   // R3
   speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctl && !srst) |=> $stable(osc_speed_o));
   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (bus_rdata == '0));
endmodule

// File: tb/tb_rtrng_ctrl.sv
module tb_rtrng_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        entropy_i = 1'b0;
   logic [1:0]  osc_speed_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   rtrng_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .entropy_i(entropy_i), .osc_speed_o(osc_speed_o)
   );

   // {len[20:19], speed[18:17], entropy[16], count[15:0]}
   localparam logic [20:0] VEC [6] = '{
      {2'd0, 2'd1, 1'b1, 16'd3},
      {2'd1, 2'd2, 1'b0, 16'd2},
      {2'd2, 2'd3, 1'b1, 16'd1},
      {2'd3, 2'd0, 1'b1, 16'd2},
      {2'd1, 2'd1, 1'b1, 16'd0},
      {2'd3, 2'd2, 1'b0, 16'd1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] v;
      int guard = 0;
      v = 32'h1;
      while (v[0] && guard < 3000) begin
         rd(12'h400, v);
         guard++;
      end
      check(req, {31'd0, v[0]}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v, w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state, R10
      rd(12'h400, v); check("R10 reset ctl", v, 32'd0);
      rd(12'h404, v); check("R7 reset count", v, 32'd1000);
      rd(12'h410, v); check("R2 reset word0", v, 32'd0);
      check("R3 reset speed", {30'd0, osc_speed_o}, 32'd0);

      // vector table: R2 R3 R4 R8 R9
      for (int i = 0; i < 6; i++) begin
         logic [1:0] len, spd;
         logic ent;
         int nw;
         {len, spd, ent} = VEC[i][20:16];
         nw = (int'(len) + 1) * 2;
         entropy_i = ent;
         wr(12'h404, {16'd0, VEC[i][15:0]});
         repeat (5) @(negedge clk);
         wr(12'h400, {16'h003F, 10'd0, len, spd, 2'b11});
         rd(12'h400, v); check("R4 start busy", {31'd0, v[0]}, 32'd1);
         wait_idle("R4 start self-clear");
         check("R3 speed out", {30'd0, osc_speed_o}, {30'd0, spd});
         for (int k = 0; k < 8; k++) begin
            rd(12'h410 + 12'(k * 4), v);
            check("R2 R9 word", v, (k < nw && ent) ? 32'hFFFF_FFFF : 32'd0);
         end
      end

      // R1 masked write: only speed changes (ctl now len3 spd2 en1)
      wr(12'h400, {16'h000C, 16'h0004});
      rd(12'h400, v); check("R1 masked write", v, 32'h0000_0036);
      check("R3 speed follows", {30'd0, osc_speed_o}, 32'd1);

      // R5 start with enable low: no effect
      entropy_i = 1'b1;
      wr(12'h400, {16'h0002, 16'h0000});
      rd(12'h410, w0);
      wr(12'h400, {16'h0001, 16'h0001});
      repeat (20) @(negedge clk);
      rd(12'h400, v); check("R5 start ignored", v, 32'h0000_0034);
      rd(12'h410, v); check("R5 words untouched", v, w0);

      // R6 abort, R8 order
      wr(12'h404, 32'd4);
      repeat (5) @(negedge clk);
      wr(12'h400, {16'h003F, 16'h0003});
      repeat (40) @(negedge clk);
      wr(12'h400, {16'h0002, 16'h0000});
      rd(12'h400, v); check("R6 abort clears start", v, 32'd0);
      repeat (30) @(negedge clk);
      rd(12'h410, w0);
      check("R6 partial kept", {31'd0, w0 != 0}, 32'd1);
      check("R8 msb-first fill", ((~w0) + 32'd1) & (~w0), 32'd0);
      check("R8 partial not full", {31'd0, w0 == 32'hFFFF_FFFF}, 32'd0);
      rd(12'h414, v); check("R8 word1 empty", v, 32'd0);

      // R7 period N=10, L=64: done at 640 cycles
      wr(12'h404, 32'd10);
      wr(12'h400, {16'h003F, 16'h0003});
      repeat (600) @(negedge clk);
      rd(12'h400, v); check("R7 busy before L*N", {31'd0, v[0]}, 32'd1);
      repeat (58) @(negedge clk);
      rd(12'h400, v); check("R7 idle after L*N", {31'd0, v[0]}, 32'd0);

      // R7 count 0 behaves as 1
      wr(12'h404, 32'd0);
      wr(12'h400, {16'h003F, 16'h0003});
      repeat (50) @(negedge clk);
      rd(12'h400, v); check("R7 zero count busy", {31'd0, v[0]}, 32'd1);
      repeat (20) @(negedge clk);
      rd(12'h400, v); check("R7 zero count done", {31'd0, v[0]}, 32'd0);

      // R9 unmapped reads
      rd(12'h408, v); check("R9 unmapped 0x408", v, 32'd0);
      rd(12'h412, v); check("R9 unaligned 0x412", v, 32'd0);
      rd(12'h430, v); check("R9 past end 0x430", v, 32'd0);

      // R11 control write on the completion edge
      wr(12'h400, {16'h003F, 16'h0003});
      repeat (63) @(negedge clk);
      wr(12'h400, {16'h000C, 16'h0008});
      rd(12'h400, v); check("R11 speed kept, start cleared", v, 32'h0000_000A);
      check("R11 speed out", {30'd0, osc_speed_o}, 32'd2);
      rd(12'h414, v); check("R11 word1 filled", v, 32'hFFFF_FFFF);
      rd(12'h418, v); check("R11 word2 empty", v, 32'd0);

      // R10 soft reset
      wr(12'h404, 32'd7);
      wr(12'h004, 32'd1);
      rd(12'h400, v); check("R10 ctl default", v, 32'd0);
      rd(12'h404, v); check("R10 count default", v, 32'd1000);
      rd(12'h410, v); check("R10 word0 cleared", v, 32'd0);
      check("R10 speed default", {30'd0, osc_speed_o}, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule